// File: doc/BRIEF.md
# I2C Two-Channel Bus Selector

This block is an I2C slave that owns a small control register. That register decides which of two downstream bus channels are joined to the upstream bus. The register is modelled only as one enable output per channel. The analog switches, level translation and pull-ups are outside the block. The block samples the upstream SCL and SDA with its system clock. SDA is driven open-drain through an output-enable.

A master selects channels by addressing the slave for write and sending a control byte. A read-addressed transfer returns the register together with the live interrupt status. Two active-low interrupt inputs, one per channel, are merged into a single active-low interrupt output. A bus-recovery reset input, active low, abandons any transfer in progress and disconnects both channels. The slave address consists of the fixed upper bits `11100` followed by the two address pins, so up to four selectors can share one bus.

Top module: `i2c_chan_selector`

## Requirements
- R1: After system reset, `chan_en` is 00 and `sda_oe` is 0.
- R2: The slave acknowledges only the 7-bit address {`11100`, `addr_pins[1]`, `addr_pins[0]`}. On any other address it leaves SDA released (no ACK), and the register keeps its value.
- R3: The first data byte after a write-addressed START sets the register. Byte bit 0 drives `chan_en[0]` and bit 1 drives `chan_en[1]`, with 1 meaning connected. Any combination, including both, is allowed.
- R4: A written value is visible on `chan_en` by the time SCL goes high for the slave's ACK of that data byte.
- R5: Each further data byte in the same write transfer overwrites the register and is acknowledged.
- R6: A read-addressed transfer returns a byte MSB first. Bits 1:0 are the register, bit 4 is the inverse of `irq_n_i[0]`, bit 5 is the inverse of `irq_n_i[1]`, and bits 7:6 and 3:2 are 0.
- R7: Written bits 7:2 have no effect. They never appear in the register or in the read-back byte.
- R8: `irq_n_o` is the AND of both `irq_n_i` bits: it is low whenever either input is low, including when both are low.
- R9: Holding `bus_rst_n` low clears `chan_en` to 00 within one clock. It also drops any transfer in progress, so later bits of that transfer are not acknowledged until a new START.
- R10: A START or STOP that arrives before the eighth bit of a data byte completes aborts that byte, and the register does not change.
- R11: A repeated START after a write begins a new address phase, so a write can be followed directly by a read without a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_rst_n | input | 1 | Active-low bus-recovery reset, sampled synchronously |
| addr_pins | input | 2 | Low two bits of the slave address |
| scl_i | input | 1 | Upstream SCL level |
| sda_i | input | 1 | Upstream SDA level |
| sda_oe | output | 1 | When 1, pulls SDA low |
| irq_n_i | input | 2 | Per-channel active-low interrupt inputs |
| irq_n_o | output | 1 | Merged active-low interrupt output |
| chan_en | output | 2 | Per-channel connect enables |

## Verification
A change on SCL or SDA passes through two synchronizer flops and one history flop. The slave therefore reacts on the third clock edge after the change: `sda_oe` and the write strobe move there, and `chan_en` moves one edge later, on the fourth. `irq_n_o` is combinational and settles in the same cycle as its inputs, while `bus_rst_n` clears `chan_en` at the next edge. The bench holds every SCL phase for at least ten clocks and samples at least ten clocks after the change that causes a result, always on the falling clock edge. This keeps every check clear of the four-cycle latency.

// File: rtl/i2c_sel_pkg.sv
// Package: shared types and constants for the I2C channel selector.
// Assumes byte-oriented I2C transfers, MSB first.
package i2c_sel_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WRITE,
        ST_ACK_WRITE,
        ST_READ,
        ST_ACK_READ
    } slave_state_t;
endpackage

// File: rtl/i2c_sel_line_sync.sv
// Module: synchronizes SCL/SDA into the clock domain and flags SCL edges,
// START and STOP. Assumes the bus idles high and the clock oversamples
// every SCL phase by several cycles.
module i2c_sel_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_q;

    // Synchronizer chains plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_q     = scl_pipe[SYNC_STAGES-1];
        sda_q     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_q & ~scl_prev;
        scl_fall  = ~scl_q & scl_prev;
        start_det = scl_q & scl_prev & sda_prev & ~sda_q;
        stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
    end
endmodule

// File: rtl/i2c_sel_slave.sv
// Module: I2C slave byte engine. Matches the address, ACKs, captures write
// data bytes and shifts out the read byte. Assumes the edge flags come from
// i2c_sel_line_sync. Writes are strobed at the start of the data ACK.
module i2c_sel_slave
    import i2c_sel_pkg::*;
#(
    parameter int         FIXED_W    = 5,
    parameter int         PIN_W      = 2,
    parameter int         REG_W      = 2,
    parameter logic [FIXED_W-1:0] ADDR_FIXED = 5'b11100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_n,
    input  logic [PIN_W-1:0] addr_pins,
    input  logic             sda_q,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic             sda_oe,
    output logic             wr_stb,
    output logic [REG_W-1:0] wr_data
);
    localparam int ADDR_W = FIXED_W + PIN_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    slave_state_t      state;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_bit;
    logic              mst_nack;
    logic [ADDR_W-1:0] my_addr;
    logic              byte_full;
    logic              addr_hit;

    // Own address and byte-complete decode.
    always_comb begin
        my_addr   = {ADDR_FIXED, addr_pins};
        byte_full = (bit_cnt == CNT_FULL);
        addr_hit  = (shreg[BYTE_W-1:1] == my_addr);
    end

    // Protocol state machine, advanced on synchronized SCL edges.
    always_ff @(posedge clk) begin
        wr_stb <= 1'b0;
        if (!rst_n || !bus_rst_n) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rw_bit   <= 1'b0;
            mst_nack <= 1'b0;
            wr_data  <= '0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_ADDR, ST_WRITE: begin
                    if (scl_rise && !byte_full) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_q};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && byte_full) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit) begin
                                state  <= ST_ACK_ADDR;
                                sda_oe <= 1'b1;
                                rw_bit <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state   <= ST_ACK_WRITE;
                            sda_oe  <= 1'b1;
                            wr_stb  <= 1'b1;
                            wr_data <= shreg[REG_W-1:0];
                        end
                    end
                end
                ST_ACK_ADDR, ST_ACK_WRITE: begin
                    if (scl_fall) begin
                        if (state == ST_ACK_ADDR && rw_bit) begin
                            state  <= ST_READ;
                            txreg  <= {rd_byte[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~rd_byte[BYTE_W-1];
                        end else begin
                            state  <= ST_WRITE;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (byte_full) begin
                            state   <= ST_ACK_READ;
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            sda_oe <= ~txreg[BYTE_W-1];
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_ACK_READ: begin
                    if (scl_rise) begin
                        mst_nack <= sda_q;
                    end else if (scl_fall) begin
                        if (mst_nack) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_READ;
                            txreg  <= {rd_byte[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~rd_byte[BYTE_W-1];
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a rejected address never leads to an ACK.
    p_release_on_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_n && !stop_det && !start_det && state == ST_ADDR && scl_fall &&
         byte_full && !addr_hit) |=> (!sda_oe && state == ST_IDLE));

    // R4: the write strobe only fires while the data ACK is being driven.
    p_strobe_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state == ST_ACK_WRITE && sda_oe));

    // R6: SDA is pulled only during ACK slots or read data.
    p_drive_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state inside {ST_ACK_ADDR, ST_ACK_WRITE, ST_READ}));

    // R9: the recovery reset idles the engine and releases SDA.
    p_pin_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> (state == ST_IDLE && !sda_oe));

    // R10: a STOP always returns to idle with SDA released.
    p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_n && stop_det) |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2c_sel_ctrl.sv
// Module: channel-enable register, read-back byte assembly and interrupt
// merge. Assumes a single-cycle write strobe from the slave engine.
module i2c_sel_ctrl
    import i2c_sel_pkg::*;
#(
    parameter int CHAN_N   = 2,
    parameter int PEND_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              wr_stb,
    input  logic [CHAN_N-1:0] wr_data,
    input  logic [CHAN_N-1:0] irq_n_i,
    output logic [CHAN_N-1:0] chan_en,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              irq_n_o
);
    // Enable register: cleared by either reset, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_rst_n) begin
            chan_en <= '0;
        end else if (wr_stb) begin
            chan_en <= wr_data;
        end
    end

    // Read-back byte: enables at the bottom, pending flags above them.
    always_comb begin
        rd_byte                      = '0;
        rd_byte[CHAN_N-1:0]          = chan_en;
        rd_byte[PEND_LSB +: CHAN_N]  = ~irq_n_i;
    end

    // Merged interrupt, built per channel so the width follows CHAN_N.
    logic [CHAN_N:0] irq_chain;
    assign irq_chain[0] = 1'b1;
    for (genvar g = 0; g < CHAN_N; g++) begin : g_irq
        assign irq_chain[g+1] = irq_chain[g] & irq_n_i[g];
    end
    assign irq_n_o = irq_chain[CHAN_N];

    // R9: the recovery reset disconnects every channel.
    p_pin_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> (chan_en == '0));

    // R10: without a strobe the enables never move.
    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_n && !wr_stb) |=> $stable(chan_en));
endmodule

// File: rtl/i2c_chan_selector.sv
// Module: top of the I2C two-channel bus selector. Connects the line
// synchronizer, the slave engine and the control register. Assumes an
// open-drain SDA, where sda_oe = 1 pulls the line low.
module i2c_chan_selector
    import i2c_sel_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [4:0]       ADDR_FIXED  = 5'b11100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst_n,
    input  logic [1:0] addr_pins,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] irq_n_i,
    output logic       irq_n_o,
    output logic [1:0] chan_en
);
    localparam int CHAN_N = 2;
    localparam int PIN_W  = 2;

    logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb;
    logic [CHAN_N-1:0] wr_data;
    logic [BYTE_W-1:0] rd_byte;

    i2c_sel_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_sel_slave #(
        .FIXED_W    (5),
        .PIN_W      (PIN_W),
        .REG_W      (CHAN_N),
        .ADDR_FIXED (ADDR_FIXED)
    ) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst_n (bus_rst_n),
        .addr_pins (addr_pins),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

    i2c_sel_ctrl #(.CHAN_N(CHAN_N), .PEND_LSB(4)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst_n (bus_rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .irq_n_i   (irq_n_i),
        .chan_en   (chan_en),
        .rd_byte   (rd_byte),
        .irq_n_o   (irq_n_o)
    );
endmodule

// File: tb/tb_i2c_chan_selector.sv
module tb_i2c_chan_selector;
    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'b1110010;   // fixed 11100 + pins 10
    localparam logic [6:0] OTHER = 7'b1110000; // pins 00: not ours

    // {data[19:12], irq_n[11:10], exp_en[9:8], exp_read[7:0]}
    localparam logic [19:0] VEC [6] = '{
        {8'h01, 2'b11, 2'b01, 8'h01},
        {8'h02, 2'b10, 2'b10, 8'h12},
        {8'h03, 2'b01, 2'b11, 8'h23},
        {8'hFF, 2'b00, 2'b11, 8'h33},
        {8'hFC, 2'b11, 2'b00, 8'h00},
        {8'h00, 2'b00, 2'b00, 8'h30}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst_n = 1'b1;
    logic [1:0] addr_pins = 2'b10;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [1:0] irq_n = 2'b11;
    logic irq_n_o;
    logic [1:0] chan_en;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_chan_selector dut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .addr_pins(addr_pins),
        .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe), .irq_n_i(irq_n),
        .irq_n_o(irq_n_o), .chan_en(chan_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b0;   wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wait_q(Q);
            scl = 1'b1;     wait_q(2*Q);
            scl = 1'b0;     wait_q(Q);
        end
    endtask

    task automatic ack_clock(output logic ack, output logic [1:0] en_at_ack);
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        ack = ~sda_line;
        en_at_ack = chan_en;
        wait_q(Q);
        scl = 1'b0;   wait_q(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic [1:0] en);
        send_bits(b, 8);
        ack_clock(ack, en);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(Q);
            scl = 1'b1; wait_q(Q);
            b[i] = sda_line;
            wait_q(Q);
            scl = 1'b0;
        end
        wait_q(Q);
        sda_m = nack; wait_q(Q);
        scl = 1'b1;   wait_q(2*Q);
        scl = 1'b0;   wait_q(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] d, output logic a_ack, output logic d_ack,
                             output logic [1:0] en);
        logic [1:0] dummy;
        bus_start();
        send_byte({DEV, 1'b0}, a_ack, dummy);
        send_byte(d, d_ack, en);
        bus_stop();
    endtask

    task automatic read_reg(output logic a_ack, output logic [7:0] d);
        logic [1:0] dummy;
        bus_start();
        send_byte({DEV, 1'b1}, a_ack, dummy);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a, d;
        logic [1:0] en;
        logic [7:0] rb;

        // R1: reset state
        wait_q(6);
        chk("R1 chan_en in reset", {6'd0, chan_en}, 8'h00);
        rst_n = 1'b1;
        wait_q(4);
        chk("R1 chan_en after reset", {6'd0, chan_en}, 8'h00);
        chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);

        // Table walk: R3, R4, R6, R7, R8
        for (int v = 0; v < 6; v++) begin
            irq_n = VEC[v][11:10];
            wait_q(2);
            chk("R8 irq merge", {7'd0, irq_n_o}, {7'd0, (VEC[v][11:10] == 2'b11)});
            write_reg(VEC[v][19:12], a, d, en);
            chk("R2 address ack", {7'd0, a}, 8'h01);
            chk("R3 data ack", {7'd0, d}, 8'h01);
            chk("R4 enable at data ack", {6'd0, en}, {6'd0, VEC[v][9:8]});
            chk("R3 chan_en", {6'd0, chan_en}, {6'd0, VEC[v][9:8]});
            read_reg(a, rb);
            chk("R6 read address ack", {7'd0, a}, 8'h01);
            chk("R6/R7 read-back byte", rb, VEC[v][7:0]);
        end
        irq_n = 2'b11;

        // R2: foreign address is not acknowledged, register unchanged
        write_reg(8'h01, a, d, en);
        bus_start();
        send_byte({OTHER, 1'b0}, a, en);
        send_byte(8'h02, d, en);
        bus_stop();
        chk("R2 foreign address nack", {7'd0, a}, 8'h00);
        chk("R2 foreign data nack", {7'd0, d}, 8'h00);
        chk("R2 register kept", {6'd0, chan_en}, 8'h01);

        // R5: several data bytes in one write
        bus_start();
        send_byte({DEV, 1'b0}, a, en);
        send_byte(8'h02, d, en);
        chk("R5 first byte", {6'd0, en}, 8'h02);
        send_byte(8'h03, d, en);
        chk("R5 second byte ack", {7'd0, d}, 8'h01);
        chk("R5 second byte", {6'd0, en}, 8'h03);
        bus_stop();

        // R10: STOP in the middle of a data byte
        write_reg(8'h01, a, d, en);
        bus_start();
        send_byte({DEV, 1'b0}, a, en);
        send_bits(8'hFE, 4);
        bus_stop();
        chk("R10 stop mid-byte keeps register", {6'd0, chan_en}, 8'h01);
        // R10: START in the middle of a data byte
        bus_start();
        send_byte({DEV, 1'b0}, a, en);
        send_bits(8'hFE, 5);
        bus_start();
        send_byte({DEV, 1'b1}, a, en);
        recv_byte(1'b1, rb);
        bus_stop();
        chk("R10 start mid-byte keeps register", rb, 8'h01);

        // R11: write then repeated START read
        bus_start();
        send_byte({DEV, 1'b0}, a, en);
        send_byte(8'h02, d, en);
        bus_start();
        send_byte({DEV, 1'b1}, a, en);
        chk("R11 repeated start address ack", {7'd0, a}, 8'h01);
        recv_byte(1'b1, rb);
        bus_stop();
        chk("R11 read after repeated start", rb, 8'h02);

        // R9: recovery reset mid-transfer
        write_reg(8'h03, a, d, en);
        bus_start();
        send_byte({DEV, 1'b0}, a, en);
        send_bits(8'h01, 4);
        bus_rst_n = 1'b0;
        wait_q(3);
        chk("R9 channels cleared", {6'd0, chan_en}, 8'h00);
        bus_rst_n = 1'b1;
        wait_q(2);
        send_bits(8'h01 << 4, 4);
        ack_clock(d, en);
        bus_stop();
        chk("R9 rest of byte not acked", {7'd0, d}, 8'h00);
        chk("R9 channels stay off", {6'd0, chan_en}, 8'h00);
        read_reg(a, rb);
        chk("R9 fresh transfer works", rb, 8'h00);

        // R8: both interrupts low together
        irq_n = 2'b00;
        wait_q(1);
        chk("R8 both low", {7'd0, irq_n_o}, 8'h00);
        irq_n = 2'b11;
        wait_q(1);
        chk("R8 both high", {7'd0, irq_n_o}, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule